// File: doc/BRIEF.md
# ADC Conversion Trigger and Result Formatter

This block decides when the analog-to-digital converter starts a conversion and how a finished 10-bit result appears to software. A small configuration register file holds a trigger select, a justification bit and two enables: one for the converter and one for automatic triggering. A multiplexer picks one of several interrupt-flag inputs according to the select value. An edge detector registers the multiplexer output on every clock, and a rising edge produces a single-cycle start pulse. Because the edge is taken after the multiplexer, rewriting the select can start a conversion by itself. The one exception is a switch into free-running mode.

In free-running mode the selected source is the converter's own completion flag, so each finished conversion launches the next one. A start marks the converter busy. Trigger edges that arrive while it is busy are discarded, not held back.

Results arrive on a valid/ready stream. The block never applies back-pressure: `res_ready` is held high, and each beat with `res_valid` high is captured and ends the busy state. The captured value is shown as two data bytes. The current justification bit shapes them at all times, so toggling that bit reformats a stored result at once.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset every register bit reads 0, `conv_start` and `conv_busy` are 0, and both data bytes are 0.
- R2: Address 0 holds the trigger select in bits 2:0 and the justification bit in bit 3, and its bits 7:4 read 0. Address 1 holds the converter enable in bit 0 and the auto-trigger enable in bit 1, and its bits 7:2 read 0. Reads are combinational on `cfg_addr`, and writes take effect at the clock edge where `cfg_we` is high.
- R3: If either enable is 0, no edge of any kind produces a start pulse.
- R4: Select codes are: 0 completion flag (free running), 1 `irq_flags[0]` (comparator), 2 `irq_flags[1]` (external interrupt 0), 3 `irq_flags[2]` (timer 0 compare A), 4 `irq_flags[3]` (timer 0 overflow). A start follows only a rising edge of the selected flag, not its level. `conv_start` goes high just after the first clock edge at which the flag is sampled high.
- R5: Select codes 5, 6 and 7 select no source, so no start is produced.
- R6: Rewriting the select from a source whose flag is low to one whose flag is high produces a start one clock after the write edge.
- R7: A write that changes the select from a non-zero code to 0 produces no start, even when the completion flag is already high.
- R8: In free-running mode a rising edge of `done_flag` starts the next conversion when both enables are 1.
- R9: A start sets `conv_busy`, and an accepted result clears it. Rising edges seen while busy are dropped, including an edge in the same cycle as the result beat.
- R10: `conv_start` never stays high for two consecutive cycles.
- R11: With justification 0, `data_hi` = {6'b0, result[9:8]} and `data_lo` = result[7:0]. With justification 1, `data_hi` = result[9:2] and `data_lo` = {result[1:0], 6'b0}.
- R12: A change of the justification bit alters the data bytes right after the write edge, whether or not a conversion is in progress.
- R13: `res_ready` is always 1, and the data bytes show the result of the most recent beat with `res_valid` high from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select (0 trigger/format, 1 enables) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` |
| irq_flags | input | 4 | Interrupt flags: comparator, ext 0, timer 0 compare A, timer 0 overflow |
| done_flag | input | 1 | Conversion-complete flag |
| res_valid | input | 1 | Result stream valid |
| res_data | input | 10 | Result stream payload |
| res_ready | output | 1 | Result stream ready, constant 1 |
| conv_start | output | 1 | One-cycle conversion start |
| conv_busy | output | 1 | Conversion in progress |
| data_hi | output | 8 | Formatted high data byte |
| data_lo | output | 8 | Formatted low data byte |

## Verification
Two pairs of events can land in the same cycle. A result beat can close a conversion in the very cycle that a trigger edge appears, and a justification write can coincide with a result capture. The bench forces both pairs in directed steps and produces them often in random traffic, where the flags toggle freely and results arrive at random. A per-cycle reference model judges each case: the edge must be dropped because busy is still set at that edge, and the bytes must show the new result in the newly written format.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int SEL_W  = 3;
  localparam int BYTE_W = 8;
  localparam int RES_W  = 10;
  localparam int N_SRC  = 4;

  typedef enum logic [2:0] {
    TRG_FREE  = 3'd0,
    TRG_ACMP  = 3'd1,
    TRG_EXT0  = 3'd2,
    TRG_T0CMP = 3'd3,
    TRG_T0OVF = 3'd4
  } trg_sel_e;
endpackage

// File: rtl/adc_trig_cfg.sv
module adc_trig_cfg
  import adc_trig_pkg::*;
#(
  parameter int P_BYTE_W = BYTE_W,
  parameter int P_SEL_W  = SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                addr,
  input  logic [P_BYTE_W-1:0] wdata,
  output logic [P_BYTE_W-1:0] rdata,
  output logic [P_SEL_W-1:0]  sel,
  output logic                ladj,
  output logic                cen,
  output logic                aen,
  output logic                enter_free
);
  // select plus justification bit are writable; everything above reads zero
  localparam logic [P_BYTE_W-1:0] CTL_MASK = P_BYTE_W'((1 << (P_SEL_W + 1)) - 1);
  localparam logic [P_BYTE_W-1:0] EN_MASK  = P_BYTE_W'(3);

  logic [P_BYTE_W-1:0] ctl_q;
  logic [P_BYTE_W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      en_q  <= '0;
    end else if (we) begin
      if (!addr) ctl_q <= wdata & CTL_MASK;
      else       en_q  <= wdata & EN_MASK;
    end
  end

  assign sel  = ctl_q[P_SEL_W-1:0];
  assign ladj = ctl_q[P_SEL_W];
  assign cen  = en_q[0];
  assign aen  = en_q[1];

  // a write that moves the select into free running from another source
  always_comb begin
    enter_free = 1'b0;
    if (we && !addr) begin
      enter_free = (trg_sel_e'(wdata[P_SEL_W-1:0]) == TRG_FREE) &&
                   (trg_sel_e'(sel) != TRG_FREE);
    end
  end

  assign rdata = addr ? en_q : ctl_q;
endmodule

// File: rtl/adc_trig_src.sv
module adc_trig_src #(
  parameter int P_SEL_W = 3,
  parameter int P_N_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_SEL_W-1:0] sel,
  input  logic               done_flag,
  input  logic [P_N_SRC-1:0] irq_flags,
  input  logic               enter_free,
  output logic               trig_rise
);
  localparam int NSEL = 1 << P_SEL_W;

  logic [NSEL-1:0] src_vec;
  logic            trig_now;
  logic            trig_q;
  logic            mask_q;

  genvar g;
  generate
    for (g = 0; g < NSEL; g++) begin : g_src
      if (g == 0) begin : g_free
        assign src_vec[g] = done_flag;
      end else if (g <= P_N_SRC) begin : g_irq
        assign src_vec[g] = irq_flags[g-1];
      end else begin : g_none
        assign src_vec[g] = 1'b0;
      end
    end
  endgenerate

  assign trig_now = src_vec[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      trig_q <= trig_now;
      mask_q <= enter_free;
    end
  end

  // the mask hides the one edge that a switch into free running could create
  assign trig_rise = trig_now & ~trig_q & ~mask_q;
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_rise,
  input  logic cen,
  input  logic aen,
  input  logic res_fire,
  output logic conv_start,
  output logic busy
);
  logic start_next;

  assign start_next = trig_rise & cen & aen & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      busy       <= 1'b0;
    end else begin
      conv_start <= start_next;
      if (start_next)    busy <= 1'b1;
      else if (res_fire) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_res_fmt.sv
module adc_res_fmt #(
  parameter int P_RES_W  = 10,
  parameter int P_BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                res_valid,
  input  logic [P_RES_W-1:0]  res_data,
  input  logic                ladj,
  output logic                res_ready,
  output logic                res_fire,
  output logic [P_BYTE_W-1:0] data_hi,
  output logic [P_BYTE_W-1:0] data_lo
);
  localparam int WORD_W = 2 * P_BYTE_W;
  localparam int PAD    = WORD_W - P_RES_W;

  logic [P_RES_W-1:0] res_q;
  logic [WORD_W-1:0]  word;

  assign res_ready = 1'b1;
  assign res_fire  = res_valid & res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        res_q <= '0;
    else if (res_fire) res_q <= res_data;
  end

  assign word    = ladj ? {res_q, {PAD{1'b0}}} : {{PAD{1'b0}}, res_q};
  assign data_hi = word[WORD_W-1:P_BYTE_W];
  assign data_lo = word[P_BYTE_W-1:0];
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int P_SEL_W  = SEL_W,
  parameter int P_BYTE_W = BYTE_W,
  parameter int P_RES_W  = RES_W,
  parameter int P_N_SRC  = N_SRC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_addr,
  input  logic [P_BYTE_W-1:0] cfg_wdata,
  output logic [P_BYTE_W-1:0] cfg_rdata,
  input  logic [P_N_SRC-1:0]  irq_flags,
  input  logic                done_flag,
  input  logic                res_valid,
  input  logic [P_RES_W-1:0]  res_data,
  output logic                res_ready,
  output logic                conv_start,
  output logic                conv_busy,
  output logic [P_BYTE_W-1:0] data_hi,
  output logic [P_BYTE_W-1:0] data_lo
);
  logic [P_SEL_W-1:0] sel_w;
  logic ladj_w, cen_w, aen_w, enter_free_w, trig_rise_w, res_fire_w;

  adc_trig_cfg #(.P_BYTE_W(P_BYTE_W), .P_SEL_W(P_SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .sel(sel_w), .ladj(ladj_w), .cen(cen_w), .aen(aen_w),
    .enter_free(enter_free_w)
  );

  adc_trig_src #(.P_SEL_W(P_SEL_W), .P_N_SRC(P_N_SRC)) u_src (
    .clk(clk), .rst_n(rst_n), .sel(sel_w), .done_flag(done_flag),
    .irq_flags(irq_flags), .enter_free(enter_free_w), .trig_rise(trig_rise_w)
  );

  adc_trig_seq u_seq (
    .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise_w), .cen(cen_w), .aen(aen_w),
    .res_fire(res_fire_w), .conv_start(conv_start), .busy(conv_busy)
  );

  adc_res_fmt #(.P_RES_W(P_RES_W), .P_BYTE_W(P_BYTE_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .ladj(ladj_w), .res_ready(res_ready), .res_fire(res_fire_w),
    .data_hi(data_hi), .data_lo(data_lo)
  );
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk #(
  parameter int P_SEL_W  = 3,
  parameter int P_BYTE_W = 8,
  parameter int P_RES_W  = 10,
  parameter int P_N_SRC  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                conv_start,
  input logic                conv_busy,
  input logic                res_valid,
  input logic [P_SEL_W-1:0]  sel,
  input logic                ladj,
  input logic                cen,
  input logic                aen,
  input logic [P_BYTE_W-1:0] cfg_rdata,
  input logic [P_BYTE_W-1:0] data_lo
);
  localparam int PAD = 2 * P_BYTE_W - P_RES_W;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R10
  AST_START_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(cen && aen)); // R3
  AST_START_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(conv_busy)); // R9
  AST_BUSY_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_busy); // R9
  AST_BUSY_CLEARS_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && res_valid) |=> (!conv_busy || conv_start)); // R9
  AST_NO_SOURCE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(sel) <= P_SEL_W'(P_N_SRC))); // R5
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[P_BYTE_W-1:P_SEL_W+1] == '0); // R2
  AST_LEFT_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ladj |-> (data_lo[PAD-1:0] == '0)); // R11
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk #(
  .P_SEL_W(P_SEL_W), .P_BYTE_W(P_BYTE_W), .P_RES_W(P_RES_W), .P_N_SRC(P_N_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_busy(conv_busy),
  .res_valid(res_valid), .sel(sel_w), .ladj(ladj_w), .cen(cen_w), .aen(aen_w),
  .cfg_rdata(cfg_rdata), .data_lo(data_lo)
);

// File: tb/adc_trig_ctrl_test.sv
module adc_trig_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [3:0] irq_flags = '0;
  logic       done_flag = 1'b0;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic       res_ready, conv_start, conv_busy;
  logic [7:0] data_hi, data_lo;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  logic [2:0] m_sel = '0;
  logic       m_ladj = 1'b0, m_cen = 1'b0, m_aen = 1'b0;
  logic       m_trq = 1'b0, m_mask = 1'b0, m_busy = 1'b0, m_start = 1'b0;
  logic [9:0] m_res = '0;

  always #5 clk = ~clk;

  adc_trig_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_flags(irq_flags),
    .done_flag(done_flag), .res_valid(res_valid), .res_data(res_data),
    .res_ready(res_ready), .conv_start(conv_start), .conv_busy(conv_busy),
    .data_hi(data_hi), .data_lo(data_lo)
  );

  function automatic logic f_mux(logic [2:0] s, logic [3:0] f, logic d);
    case (s)
      3'd0: return d;
      3'd1: return f[0];
      3'd2: return f[1];
      3'd3: return f[2];
      3'd4: return f[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] f_fmt(logic [9:0] r, logic l);
    return l ? {r, 6'b0} : {6'b0, r};
  endfunction

  function automatic logic [7:0] f_rd(logic a);
    return a ? {6'b0, m_aen, m_cen} : {4'b0, m_ladj, m_sel};
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic now, rise, st;
    now  = f_mux(m_sel, irq_flags, done_flag);
    rise = now & ~m_trq & ~m_mask;
    st   = rise & m_aen & m_cen & ~m_busy;
    m_busy  = st | (m_busy & ~res_valid);
    m_start = st;
    m_trq   = now;
    m_mask  = cfg_we && !cfg_addr && cfg_wdata[2:0] == 3'd0 && m_sel != 3'd0;
    if (cfg_we) begin
      if (!cfg_addr) begin m_sel = cfg_wdata[2:0]; m_ladj = cfg_wdata[3]; end
      else begin m_cen = cfg_wdata[0]; m_aen = cfg_wdata[1]; end
    end
    if (res_valid) m_res = res_data;
  endtask

  task automatic compare_all();
    chk({15'b0, conv_start}, {15'b0, m_start}, "R4 start vs model");
    chk({15'b0, conv_busy}, {15'b0, m_busy}, "R9 busy vs model");
    chk({data_hi, data_lo}, f_fmt(m_res, m_ladj), "R11 data vs model");
    chk({8'b0, cfg_rdata}, {8'b0, f_rd(cfg_addr)}, "R2 rdata vs model");
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cfg_addr = 1'b0; #1;
    chk({8'b0, cfg_rdata}, 16'h0000, "R1 ctl after reset");
    cfg_addr = 1'b1; #1;
    chk({8'b0, cfg_rdata}, 16'h0000, "R1 enables after reset");
    chk({14'b0, conv_start, conv_busy}, 16'h0000, "R1 start/busy after reset");
    chk({data_hi, data_lo}, 16'h0000, "R1 data after reset");
    // R2 register map
    wr(1'b0, 8'hFF); cfg_addr = 1'b0; #1;
    chk({8'b0, cfg_rdata}, 16'h000F, "R2 ctl readback");
    wr(1'b1, 8'hFF); cfg_addr = 1'b1; #1;
    chk({8'b0, cfg_rdata}, 16'h0003, "R2 enable readback");
    // R3 auto-trigger off
    wr(1'b1, 8'h01); wr(1'b0, 8'h01);
    irq_flags[0] = 1'b1; tick();
    chk({15'b0, conv_start}, 16'h0, "R3 no start with auto off");
    irq_flags[0] = 1'b0; tick();
    // R4 rising edge start, R10 single pulse
    wr(1'b1, 8'h03);
    irq_flags[0] = 1'b1; tick();
    chk({15'b0, conv_start}, 16'h1, "R4 start on rising edge");
    tick();
    chk({15'b0, conv_start}, 16'h0, "R10 pulse one cycle, level no retrigger");
    // R13 result beat
    res_valid = 1'b1; res_data = 10'h2A5; tick(); res_valid = 1'b0;
    chk({15'b0, res_ready}, 16'h1, "R13 ready high");
    tick();
    chk({15'b0, conv_busy}, 16'h0, "R9 busy cleared by result");
    chk({data_hi, data_lo}, 16'h02A5, "R11 right justified");
    // R12 immediate justification change
    wr(1'b0, 8'h09);
    chk({data_hi, data_lo}, 16'hA940, "R12 left justified after write");
    // R5 unused codes
    irq_flags = '0; wr(1'b0, 8'h05);
    irq_flags = 4'hF; tick(); tick();
    chk({15'b0, conv_start}, 16'h0, "R5 code 5 no start");
    // R6 select switch creates edge
    irq_flags = 4'b0010; wr(1'b0, 8'h01);
    wr(1'b0, 8'h02);
    chk({15'b0, conv_start}, 16'h0, "R6 no start at write edge");
    tick();
    chk({15'b0, conv_start}, 16'h1, "R6 start after select switch");
    res_valid = 1'b1; res_data = 10'h155; tick(); res_valid = 1'b0;
    // R7 switch into free running
    irq_flags = '0; done_flag = 1'b1; wr(1'b0, 8'h03); tick();
    wr(1'b0, 8'h00);
    chk({15'b0, conv_start}, 16'h0, "R7 no start at write");
    tick();
    chk({15'b0, conv_start}, 16'h0, "R7 no start entering free running");
    // R8 free running
    done_flag = 1'b0; tick();
    done_flag = 1'b1; tick();
    chk({15'b0, conv_start}, 16'h1, "R8 free-running restart");
    // R9 edge while busy dropped
    done_flag = 1'b0; tick();
    done_flag = 1'b1; tick();
    chk({15'b0, conv_start}, 16'h0, "R9 edge while busy dropped");
    done_flag = 1'b0; tick();
    done_flag = 1'b1; res_valid = 1'b1; res_data = 10'h3C3; tick();
    res_valid = 1'b0;
    chk({15'b0, conv_start}, 16'h0, "R9 edge with result beat dropped");
    chk({15'b0, conv_busy}, 16'h0, "R9 busy low after beat");
    // random traffic, with justification writes and result beats colliding
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < 4; b++) if ($urandom % 4 == 0) irq_flags[b] = ~irq_flags[b];
      if ($urandom % 5 == 0) done_flag = ~done_flag;
      res_valid = (m_busy && ($urandom % 4 == 0)) || ($urandom % 40 == 0);
      res_data  = 10'($urandom);
      cfg_we    = ($urandom % 8 == 0);
      cfg_addr  = ($urandom % 6 == 0);
      cfg_wdata = cfg_addr ? (($urandom % 5 == 0) ? 8'($urandom) : 8'h03)
                           : 8'($urandom % 16);
      tick();
      cfg_we = 1'b0;
    end
    summary();
    $finish;
  end
endmodule